// File: doc/BRIEF.md
# Fractional Output Clock Divider with Triangle Spread

This block derives a slower output clock from a fast source clock. The divide value has a 12-bit integer part and a 24-bit fraction. A first-order phase accumulator adds the fraction once per output period. When that sum carries out, the next period is one source cycle longer, so the mean period matches the programmed value.

The mode input selects one of three behaviours. Integer mode uses the integer part alone. Fractional mode uses the integer part, the fraction and the accumulator. Bypass mode passes the source clock straight through. An optional spread modulator moves the divide value up and down around its centre along a triangle wave. The ramp step, the step interval and the peak are all programmable, so software can place the modulation rate anywhere in the tens-of-kilohertz range.

Several instances can share one `sync_start_i` pulse. They then begin their periods on the same source edge, and dividers with integer ratios of the same source stay edge aligned.

Top module: `fdiv_top`

## Requirements
- R1: After reset, and until the first `sync_start_i`, `period_end_o` and `div_clk_o` are both 0.
- R2: Integer mode (`mode_i` = 0) produces periods of exactly N = `div_int_i` source cycles. Cycle 0 is the first cycle after the clock edge that captures `sync_start_i`. With that numbering, `period_end_o` is high in cycle p·N − 1 for the p-th period.
- R3: In integer mode, `div_frac_i` and the spread modulator have no effect on the period timing.
- R4: Outside bypass, a `div_int_i` below 2 acts as 2. In fractional mode, an effective divide value below 2.0 acts as exactly 2.0.
- R5: Fractional mode (`mode_i` = 1; code 3 behaves the same) with fraction F ends the p-th period in cycle p·N + ⌊(p−1)·F / 2^24⌋ − 1, with cycles numbered as in R2.
- R6: A period of L cycles holds `div_clk_o` high for its first ⌊L/2⌋ cycles and low for the remaining ⌈L/2⌉ cycles.
- R7: In bypass mode (`mode_i` = 2), once started, `period_end_o` is high in every cycle and `div_clk_o` follows `clk_i`.
- R8: A `sync_start_i` during operation discards the period in progress and clears the accumulator. The timing of R2 and R5 then restarts from that pulse.
- R9: With `ssc_en_i` = 1 in fractional mode, a signed offset is added to the divide value, in units of 2^-24. The offset starts at 0 on `sync_start_i` and moves by `ssc_step_i` once every `ssc_rate_i`+1 cycles. It stays within ±`ssc_peak_i` and reverses direction at each bound. Over whole triangle cycles the mean period equals the centre value.
- R10: Under spread, no period is shorter than 2 source cycles. The offset saturates the effective divide value at 2.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sync_start_i | input | 1 | Start/alignment pulse; restarts counter, accumulator and spread |
| mode_i | input | 2 | 0 integer, 1 fractional, 2 bypass, 3 as fractional |
| div_int_i | input | 12 | Integer part of the divide value |
| div_frac_i | input | 24 | Fractional part, units of 2^-24 |
| ssc_en_i | input | 1 | Enables the triangle spread offset |
| ssc_rate_i | input | 16 | Source cycles between spread steps, minus one |
| ssc_step_i | input | 24 | Offset change per step, units of 2^-24 |
| ssc_peak_i | input | 25 | Offset magnitude bound, units of 2^-24 |
| div_clk_o | output | 1 | Divided output clock |
| period_end_o | output | 1 | High in the last source cycle of each output period |

## Verification
If the accumulator value is wrong, the carry shifts to a different period. The cumulative end-cycle count then departs from the closed-form sum within one or two periods. That is why the bench compares every period end against the formula, not only the mean. A stuck or misdirected spread offset shows up over a single triangle cycle as a drift of the total cycle count, or as period lengths outside the expected band. A wrong reload or duty threshold is visible in the first period after `sync_start_i`.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
// Shared types for the fractional divider.
package fdiv_pkg;
    // Operating mode; code 3 is treated as fractional.
    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_FRAC = 2'd1,
        MODE_BYP  = 2'd2,
        MODE_RSVD = 2'd3
    } div_mode_e;
endpackage

// File: rtl/fdiv_spread.sv
`timescale 1ns/1ps
// Triangle offset generator.
// Emits a signed offset (units of 2^-FW) that ramps by step_i every rate_i+1
// cycles, clamps at +/-peak_i and reverses there. Assumes step_i and peak_i
// are held steady while enabled.
module fdiv_spread #(
    parameter int FW = 24,
    parameter int SW = FW + 2,
    parameter int RW = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 restart_i,
    input  logic                 en_i,
    input  logic [RW-1:0]        rate_i,
    input  logic [FW-1:0]        step_i,
    input  logic [SW-2:0]        peak_i,
    output logic signed [SW-1:0] offset_o
);
    logic [RW-1:0]        tmr_q;
    logic signed [SW-1:0] off_q;
    logic                 dir_dn_q;
    logic signed [SW:0]   pk_s, neg_pk, off_x, up_s, dn_s;

    // Sign-extended working values for the ramp comparison.
    always_comb begin
        pk_s   = $signed({2'b00, peak_i});
        neg_pk = -pk_s;
        off_x  = {off_q[SW-1], off_q};
        up_s   = off_x + $signed({{(SW+1-FW){1'b0}}, step_i});
        dn_s   = off_x - $signed({{(SW+1-FW){1'b0}}, step_i});
    end

    // Step timer and ramp with reversal at the bounds.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || restart_i || !en_i) begin
            tmr_q    <= rate_i;
            off_q    <= '0;
            dir_dn_q <= 1'b0;
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - RW'(1);
        end else begin
            tmr_q <= rate_i;
            if (!dir_dn_q) begin
                if (up_s >= pk_s) begin
                    off_q    <= pk_s[SW-1:0];
                    dir_dn_q <= 1'b1;
                end else begin
                    off_q <= up_s[SW-1:0];
                end
            end else begin
                if (dn_s <= neg_pk) begin
                    off_q    <= neg_pk[SW-1:0];
                    dir_dn_q <= 1'b0;
                end else begin
                    off_q <= dn_s[SW-1:0];
                end
            end
        end
    end

    assign offset_o = off_q;

    // R9: offset stays inside the programmed band
    p_off_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> ((off_x <= pk_s) && (off_x >= neg_pk)));

    // R9: offset only moves when the step timer expires
    p_off_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !restart_i && tmr_q != '0) |=> $stable(off_q));
endmodule

// File: rtl/fdiv_target.sv
`timescale 1ns/1ps
// Effective divide value.
// Adds the spread offset to the fixed-point divide value when the fraction is
// in use, then saturates to [2.0, max]. Purely combinational.
module fdiv_target #(
    parameter int IW = 12,
    parameter int FW = 24,
    parameter int SW = FW + 2
) (
    input  logic                 frac_en_i,
    input  logic [IW-1:0]        int_i,
    input  logic [FW-1:0]        frac_i,
    input  logic signed [SW-1:0] off_i,
    output logic [IW-1:0]        int_o,
    output logic [FW-1:0]        frac_o
);
    localparam int TW = IW + FW + 2;
    localparam logic signed [TW-1:0] MIN_V = $signed({{IW{1'b0}}, 2'b10, {FW{1'b0}}});
    localparam logic signed [TW-1:0] MAX_V = $signed({2'b00, {(IW+FW){1'b1}}});

    logic signed [TW-1:0] base_s, off_s, sum_s, sat_s;

    // Sum the centre value and offset, then clamp into the legal range.
    always_comb begin
        base_s = $signed({2'b00, int_i, (frac_en_i ? frac_i : {FW{1'b0}})});
        off_s  = frac_en_i ? $signed({{(TW-SW){off_i[SW-1]}}, off_i}) : '0;
        sum_s  = base_s + off_s;
        if (sum_s < MIN_V)      sat_s = MIN_V;
        else if (sum_s > MAX_V) sat_s = MAX_V;
        else                    sat_s = sum_s;
    end

    assign {int_o, frac_o} = (IW+FW)'(sat_s);
endmodule

// File: rtl/fdiv_core.sv
`timescale 1ns/1ps
// Period counter with first-order fractional accumulator.
// Each period's length is the integer value plus the carry of acc+frac taken
// at the previous period end. Assumes int_i >= 2 (guaranteed by fdiv_target).
module fdiv_core #(
    parameter int IW = 12,
    parameter int FW = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sync_i,
    input  logic          byp_i,
    input  logic [IW-1:0] int_i,
    input  logic [FW-1:0] frac_i,
    output logic          running_o,
    output logic          div_o,
    output logic          period_end_o
);
    localparam int LW = IW + 1;

    logic          running_q, div_q, div_d, load;
    logic [IW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] thr_q, thr_d, len_sel;
    logic [FW-1:0] acc_q;
    logic [FW:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};

    // Next count, high-phase threshold and output level.
    always_comb begin
        load    = sync_i || (running_q && (cnt_q == '0));
        len_sel = sync_i ? {1'b0, int_i}
                         : ({1'b0, int_i} + {{IW{1'b0}}, acc_sum[FW]});
        if (load) begin
            cnt_d = IW'(len_sel - LW'(1));
            thr_d = len_sel - (len_sel >> 1);
        end else if (running_q) begin
            cnt_d = cnt_q - IW'(1);
            thr_d = thr_q;
        end else begin
            cnt_d = cnt_q;
            thr_d = thr_q;
        end
        div_d = (running_q || sync_i) && ({1'b0, cnt_d} >= thr_d);
    end

    // State registers; sync clears the accumulator and starts running.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            thr_q     <= '0;
            acc_q     <= '0;
            div_q     <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            thr_q <= thr_d;
            div_q <= div_d;
            if (sync_i) begin
                running_q <= 1'b1;
                acc_q     <= '0;
            end else if (load) begin
                acc_q <= acc_sum[FW-1:0];
            end
        end
    end

    assign running_o    = running_q;
    assign div_o        = div_q;
    assign period_end_o = running_q && (byp_i || (cnt_q == '0));

    // R10: the value feeding each reload is never below 2
    p_int_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |-> (int_i >= IW'(2)));

    // R8: a start pulse restarts counter and accumulator
    p_sync_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> (running_q && acc_q == '0 && cnt_q == IW'($past(int_i) - 1'b1)));

    // R3: with no fraction applied the accumulator holds
    p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_i && frac_i == '0) |=> $stable(acc_q));

    // R6: the last cycle of a period is in the low phase
    p_end_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_q && cnt_q == '0) |-> !div_q);
endmodule

// File: rtl/fdiv_top.sv
`timescale 1ns/1ps
// Fractional output divider with triangle spread and bypass.
// Combines spread generator, target saturation and period counter. Outputs
// are idle until the first sync_start_i.
module fdiv_top #(
    parameter int IW = 12,
    parameter int FW = 24,
    parameter int RW = 16,
    parameter int SW = FW + 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sync_start_i,
    input  logic [1:0]    mode_i,
    input  logic [IW-1:0] div_int_i,
    input  logic [FW-1:0] div_frac_i,
    input  logic          ssc_en_i,
    input  logic [RW-1:0] ssc_rate_i,
    input  logic [FW-1:0] ssc_step_i,
    input  logic [SW-2:0] ssc_peak_i,
    output logic          div_clk_o,
    output logic          period_end_o
);
    import fdiv_pkg::*;

    div_mode_e            mode;
    logic                 byp, frac_en, running, div_q;
    logic signed [SW-1:0] offset;
    logic [IW-1:0]        int_eff;
    logic [FW-1:0]        frac_eff;

    assign mode    = div_mode_e'(mode_i);
    assign byp     = (mode == MODE_BYP);
    assign frac_en = (mode == MODE_FRAC) || (mode == MODE_RSVD);

    fdiv_spread #(.FW(FW), .SW(SW), .RW(RW)) u_spread (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (sync_start_i),
        .en_i      (ssc_en_i),
        .rate_i    (ssc_rate_i),
        .step_i    (ssc_step_i),
        .peak_i    (ssc_peak_i),
        .offset_o  (offset)
    );

    fdiv_target #(.IW(IW), .FW(FW), .SW(SW)) u_target (
        .frac_en_i (frac_en),
        .int_i     (div_int_i),
        .frac_i    (div_frac_i),
        .off_i     (offset),
        .int_o     (int_eff),
        .frac_o    (frac_eff)
    );

    fdiv_core #(.IW(IW), .FW(FW)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sync_i       (sync_start_i),
        .byp_i        (byp),
        .int_i        (int_eff),
        .frac_i       (frac_eff),
        .running_o    (running),
        .div_o        (div_q),
        .period_end_o (period_end_o)
    );

    assign div_clk_o = (byp && running) ? clk_i : div_q;

    // R7: in bypass every cycle closes a period once started
    p_byp_every_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byp && running && !sync_start_i) |-> period_end_o);
endmodule

// File: tb/tb_fdiv_top.sv
`timescale 1ns/1ps
module tb_fdiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [11:0] dint = 12'd4;
    logic [23:0] dfrac = '0;
    logic        ssc_en = 1'b0;
    logic [15:0] ssc_rate = '0;
    logic [23:0] ssc_step = '0;
    logic [24:0] ssc_peak = '0;
    logic        div_clk, period_end;

    int     n_tests = 0;
    int     n_fail  = 0;
    longint ends_a [0:1023];
    int     got_n;

    always #2 clk = ~clk;

    fdiv_top dut (
        .clk_i(clk), .rst_ni(rst_n), .sync_start_i(sync_start), .mode_i(mode),
        .div_int_i(dint), .div_frac_i(dfrac), .ssc_en_i(ssc_en),
        .ssc_rate_i(ssc_rate), .ssc_step_i(ssc_step), .ssc_peak_i(ssc_peak),
        .div_clk_o(div_clk), .period_end_o(period_end)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input int i, input longint f, input bit en,
                       input int rate, input longint step, input longint peak);
        @(negedge clk);
        mode = m; dint = 12'(i); dfrac = 24'(f); ssc_en = en;
        ssc_rate = 16'(rate); ssc_step = 24'(step); ssc_peak = 25'(peak);
    endtask

    // Pulse sync; returns at the negedge that is cycle 0.
    task automatic start_sync();
        @(negedge clk) sync_start = 1'b1;
        @(negedge clk) sync_start = 1'b0;
    endtask

    task automatic collect(input int p_cnt);
        longint k;
        k = 0;
        got_n = 0;
        while (got_n < p_cnt && k < 20000) begin
            if (period_end) begin
                ends_a[got_n] = k;
                got_n++;
            end
            if (got_n < p_cnt) begin
                @(negedge clk);
                k++;
            end
        end
    endtask

    function automatic longint exp_end(input longint n, input longint f, input longint p);
        return p * n + (((p - 1) * f) >> 24) - 1;
    endfunction

    // Compare every period end with the closed-form schedule.
    task automatic check_sched(input string tag, input int n, input longint f, input int p_cnt);
        longint bad_act, bad_exp;
        int errs;
        errs = 0; bad_act = 0; bad_exp = 0;
        collect(p_cnt);
        for (int p = 1; p <= got_n; p++) begin
            if (ends_a[p-1] != exp_end(n, f, p)) begin
                if (errs == 0) begin bad_act = ends_a[p-1]; bad_exp = exp_end(n, f, p); end
                errs++;
            end
        end
        if (got_n != p_cnt) begin errs++; bad_act = got_n; bad_exp = p_cnt; end
        check(errs == 0, tag, bad_act, bad_exp);
    endtask

    task automatic len_range(input int p_cnt, output longint mn, output longint mx, output longint tot);
        longint l;
        collect(p_cnt);
        mn = 1 << 30; mx = 0;
        for (int p = 0; p < got_n; p++) begin
            l = (p == 0) ? ends_a[0] + 1 : ends_a[p] - ends_a[p-1];
            if (l < mn) mn = l;
            if (l > mx) mx = l;
        end
        tot = (got_n > 0) ? ends_a[got_n-1] + 1 : 0;
    endtask

    initial begin : watchdog
        #(190000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        longint mn, mx, tot;
        int hi_err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle before the first start pulse
        begin
            int bad;
            bad = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (period_end !== 1'b0 || div_clk !== 1'b0) bad++;
            end
            check(bad == 0, "R1 idle outputs after reset", bad, 0);
        end

        // R2: integer sweep
        for (int n = 2; n <= 12; n++) begin
            cfg(2'd0, n, 0, 0, 0, 0, 0);
            start_sync();
            check_sched($sformatf("R2 integer N=%0d", n), n, 0, 20);
        end

        // R3: fraction and spread ignored in integer mode
        cfg(2'd0, 7, 24'h800000, 1, 0, 24'h100000, 25'h1000000);
        start_sync();
        check_sched("R3 integer ignores frac/spread", 7, 0, 40);

        // R4: low integer values act as 2
        cfg(2'd0, 0, 0, 0, 0, 0, 0);
        start_sync();
        check_sched("R4 N=0 acts as 2", 2, 0, 16);
        cfg(2'd0, 1, 0, 0, 0, 0, 0);
        start_sync();
        check_sched("R4 N=1 acts as 2", 2, 0, 16);
        cfg(2'd1, 1, 24'h400000, 0, 0, 0, 0);
        start_sync();
        check_sched("R4 frac 1.25 acts as 2.0", 2, 0, 16);
        cfg(2'd1, 0, 24'hFFFFFF, 0, 0, 0, 0);
        start_sync();
        check_sched("R4 frac 0.99 acts as 2.0", 2, 0, 16);

        // R5: fractional sweep
        cfg(2'd1, 3, 24'h800000, 0, 0, 0, 0);  start_sync();
        check_sched("R5 3.5", 3, 24'h800000, 200);
        cfg(2'd1, 2, 24'h555555, 0, 0, 0, 0);  start_sync();
        check_sched("R5 2.333", 2, 24'h555555, 200);
        cfg(2'd1, 5, 24'h100000, 0, 0, 0, 0);  start_sync();
        check_sched("R5 5.0625", 5, 24'h100000, 200);
        cfg(2'd1, 4, 24'hFFFFFF, 0, 0, 0, 0);  start_sync();
        check_sched("R5 4.999", 4, 24'hFFFFFF, 200);
        cfg(2'd3, 9, 24'h2AAAAA, 0, 0, 0, 0);  start_sync();
        check_sched("R5 mode3 9.1667", 9, 24'h2AAAAA, 200);

        // R6: duty over two periods
        for (int n = 2; n <= 9; n++) begin
            cfg(2'd0, n, 0, 0, 0, 0, 0);
            start_sync();
            hi_err = 0;
            for (int k = 0; k < 2 * n; k++) begin
                if (k > 0) @(negedge clk);
                if (div_clk !== ((k % n) < (n / 2))) hi_err++;
            end
            check(hi_err == 0, $sformatf("R6 duty L=%0d", n), hi_err, 0);
        end

        // R7: bypass
        cfg(2'd2, 5, 0, 0, 0, 0, 0);
        start_sync();
        begin
            int bad_pe, bad_hi, bad_lo;
            bad_pe = 0; bad_hi = 0; bad_lo = 0;
            for (int c = 0; c < 20; c++) begin
                if (period_end !== 1'b1) bad_pe++;
                if (div_clk !== 1'b0) bad_lo++;
                @(posedge clk); #1;
                if (div_clk !== 1'b1) bad_hi++;
                @(negedge clk);
            end
            check(bad_pe == 0, "R7 bypass period_end every cycle", bad_pe, 0);
            check(bad_hi + bad_lo == 0, "R7 bypass div_clk follows clk", bad_hi + bad_lo, 0);
        end

        // R8: restart mid-run
        cfg(2'd1, 3, 24'h800000, 0, 0, 0, 0);
        start_sync();
        collect(7);
        repeat (2) @(negedge clk);
        start_sync();
        check_sched("R8 resync restarts schedule", 3, 24'h800000, 30);

        // R9: spread mean and spread band
        cfg(2'd1, 4, 0, 1, 3, 24'h040000, 25'h0400000);
        start_sync();
        len_range(1024, mn, mx, tot);
        check((tot >= 4096 - 12) && (tot <= 4096 + 12), "R9 spread mean period", tot, 4096);
        check((mn >= 3) && (mx <= 5) && (mn != mx), "R9 spread band min", mn, 3);

        // R10: saturation at 2.0
        cfg(2'd1, 2, 0, 1, 1, 24'h100000, 25'h0800000);
        start_sync();
        len_range(512, mn, mx, tot);
        check(mn == 2, "R10 min period under spread", mn, 2);
        check(mx == 3, "R10 max period under spread", mx, 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule